// File: doc/BRIEF.md
# Single-Wire Pulse-Width Brightness Decoder

This block receives brightness commands over one normally-high, active-low line that can be driven by an open-drain host. Every symbol is a low pulse followed by a return to high. The block classifies each pulse by its width alone. A short pulse is a data one, a medium pulse is a data zero, and a very long pulse is a load command. The width is measured in ticks of a reference time base, which is derived from the block clock by a parameterised divider.

Data bits enter a 5-bit shift register most significant bit first. A load command copies the five most recent bits into the brightness output and raises a one-cycle update strobe. A low pulse whose width lies outside every window is dropped. A pulse that follows too short a high interval is also dropped. Taking the enable input low clears the shift register and the brightness output. The previous value is not restored when enable returns; the host must send the setting again.

Top module: `swire_dim_decoder`

## Requirements
- R1: After reset, and with the line idle high, `level` is 0 and `strobe` is 0.
- R2: Bits are shifted in most significant first. The sequence one, zero, one, zero, zero followed by a load gives `level` = 5'b10100 (20).
- R3: A low pulse whose width is from 15 to 45 ticks inclusive shifts in a 1.
- R4: A low pulse whose width is from 90 to 120 ticks inclusive shifts in a 0.
- R5: A low pulse of at least 216 ticks is a load. It copies the shift register to `level` and holds `strobe` high for exactly one cycle. `level` changes only together with `strobe`, or when the block is disabled.
- R6: Low pulses of 14 ticks or less, 46 to 89 ticks, or 121 to 215 ticks are discarded and leave the shift register unchanged.
- R7: A low pulse that follows a high interval shorter than 3 ticks is discarded. A high interval of exactly 3 ticks is accepted.
- R8: While `en` is low, the shift register, `level` and `strobe` are held at 0 from the next clock edge, and line activity is ignored. After `en` returns, `level` stays 0 until a new load.
- R9: `level` and `strobe` update on the third rising clock edge after the line rises at the end of a load pulse: two synchronizer stages plus one output register.
- R10: The width counter saturates, so a low pulse of any length at or above 216 ticks, for example 700 ticks, is still decoded as a load.
- R11: When more than five bits are sent before a load, only the last five received reach `level`.
- R12: Width is counted in whole ticks of TICK_DIV clock cycles, starting at the cycle in which the synchronized line changes level. A run of L cycles therefore measures floor(L/TICK_DIV) ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; TICK_DIV cycles make one tick |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enable; low clears all state synchronously |
| line_in | input | 1 | Raw single-wire line, idles high |
| level | output | LEVEL_W (5) | Current brightness setting |
| strobe | output | 1 | One-cycle pulse when `level` is loaded |

## Verification
A load pulse ending at a line rise is due at the outputs on the third clock edge after the rise, and a low `en` takes effect on the first edge. The bench drives the line just after a rising edge and samples on the falling edge. A behavioural model, written with integer run lengths, is stepped once per clock, so every output is compared in the exact cycle in which it is due. Directed checks confirm the latency edge by edge around one load. Other directed checks read `level` only after a high gap longer than the three-cycle latency, and count strobes to catch spurious or missing loads.

// File: rtl/swire_dim_pkg.sv
package swire_dim_pkg;
  typedef enum logic [1:0] {
    SYM_NONE = 2'd0,
    SYM_ONE  = 2'd1,
    SYM_ZERO = 2'd2,
    SYM_LOAD = 2'd3
  } sym_t;
endpackage

// File: rtl/swire_sync.sv
module swire_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  // Reset to the idle (high) level of the line.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= '1;
    else        ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/swire_pulse_meter.sv
module swire_pulse_meter
  import swire_dim_pkg::*;
#(
  parameter int TICK_DIV = 50,
  parameter int ONE_MIN  = 15,
  parameter int ONE_MAX  = 45,
  parameter int ZERO_MIN = 90,
  parameter int ZERO_MAX = 120,
  parameter int LOAD_MIN = 216,
  parameter int HIGH_MIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic s,
  output sym_t sym
);
  localparam int RUN_MAX = LOAD_MIN;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam int PC_W    = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  // The cycle in which the level changes is the first cycle of the new run.
  localparam logic [PC_W-1:0]  PC_START  = (TICK_DIV == 1) ? PC_W'(0) : PC_W'(1);
  localparam logic [RUN_W-1:0] RUN_START = (TICK_DIV == 1) ? RUN_W'(1) : RUN_W'(0);

  logic             s_d;
  logic [PC_W-1:0]  pc;
  logic [RUN_W-1:0] run;
  logic             hi_ok;
  logic             edge_w, rise_w, fall_w, tick_w;

  assign edge_w = s ^ s_d;
  assign rise_w = s & ~s_d;
  assign fall_w = ~s & s_d;
  assign tick_w = (pc == PC_W'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_d   <= 1'b1;
      pc    <= '0;
      run   <= '0;
      hi_ok <= 1'b0;
    end else if (!en) begin
      s_d   <= 1'b1;
      pc    <= '0;
      run   <= '0;
      hi_ok <= 1'b0;
    end else begin
      s_d <= s;
      if (edge_w) begin
        // Qualify the high interval that precedes a new low pulse.
        if (fall_w) hi_ok <= (run >= RUN_W'(HIGH_MIN));
        pc  <= PC_START;
        run <= RUN_START;
      end else if (tick_w) begin
        pc <= '0;
        if (run != RUN_W'(RUN_MAX)) run <= run + RUN_W'(1);
      end else begin
        pc <= pc + PC_W'(1);
      end
    end
  end

  // Classify on the rising edge of the synchronized line.
  always_comb begin
    sym = SYM_NONE;
    if (en && rise_w && hi_ok) begin
      if (run >= RUN_W'(ONE_MIN) && run <= RUN_W'(ONE_MAX))        sym = SYM_ONE;
      else if (run >= RUN_W'(ZERO_MIN) && run <= RUN_W'(ZERO_MAX)) sym = SYM_ZERO;
      else if (run >= RUN_W'(LOAD_MIN))                            sym = SYM_LOAD;
    end
  end
endmodule

// File: rtl/swire_bit_store.sv
module swire_bit_store
  import swire_dim_pkg::*;
#(
  parameter int LEVEL_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  sym_t               sym,
  output logic [LEVEL_W-1:0] level,
  output logic               strobe
);
  logic [LEVEL_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      level  <= '0;
      strobe <= 1'b0;
    end else if (!en) begin
      shreg  <= '0;
      level  <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= 1'b0;
      case (sym)
        SYM_ONE:  shreg <= {shreg[LEVEL_W-2:0], 1'b1};
        SYM_ZERO: shreg <= {shreg[LEVEL_W-2:0], 1'b0};
        SYM_LOAD: begin
          level  <= shreg;
          strobe <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/swire_dim_decoder.sv
module swire_dim_decoder
  import swire_dim_pkg::*;
#(
  parameter int LEVEL_W     = 5,
  parameter int SYNC_STAGES = 2,
  parameter int TICK_DIV    = 50,
  parameter int ONE_MIN     = 15,
  parameter int ONE_MAX     = 45,
  parameter int ZERO_MIN    = 90,
  parameter int ZERO_MAX    = 120,
  parameter int LOAD_MIN    = 216,
  parameter int HIGH_MIN    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               line_in,
  output logic [LEVEL_W-1:0] level,
  output logic               strobe
);
  logic line_s;
  sym_t sym;

  swire_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
  );

  swire_pulse_meter #(
    .TICK_DIV(TICK_DIV), .ONE_MIN(ONE_MIN), .ONE_MAX(ONE_MAX),
    .ZERO_MIN(ZERO_MIN), .ZERO_MAX(ZERO_MAX), .LOAD_MIN(LOAD_MIN),
    .HIGH_MIN(HIGH_MIN)
  ) u_meter (
    .clk(clk), .rst_n(rst_n), .en(en), .s(line_s), .sym(sym)
  );

  swire_bit_store #(.LEVEL_W(LEVEL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .en(en), .sym(sym),
    .level(level), .strobe(strobe)
  );
endmodule

// File: rtl/swire_dim_decoder_chk.sv
module swire_dim_decoder_chk #(
  parameter int LEVEL_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               s_line,
  input logic [LEVEL_W-1:0] level,
  input logic               strobe
);
  // R5: the update strobe never lasts two cycles
  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  // R5: the setting moves only with a strobe while enabled
  assert_level_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !strobe) |-> $stable(level));

  // R8: disabling clears the outputs at the next edge
  assert_disable_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (level == '0 && !strobe));

  // R9: a strobe follows a rise of the synchronized line by one register
  assert_strobe_after_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> ($past(s_line, 1) && !$past(s_line, 2)));
endmodule

bind swire_dim_decoder swire_dim_decoder_chk #(.LEVEL_W(LEVEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .s_line(line_s),
  .level(level), .strobe(strobe)
);

// File: tb/swire_dim_decoder_tb.sv
`timescale 1ns/1ps
module swire_dim_decoder_tb;
  localparam int TD = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       line = 1'b1;
  logic [4:0] level;
  logic       strobe;

  int checks = 0;
  int fails = 0;
  int nstrobe = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  swire_dim_decoder #(.TICK_DIV(TD)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .line_in(line),
    .level(level), .strobe(strobe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model, stepped once per rising clock edge.
  int mq1 = 1, mq2 = 1, mprev = 1, mlen = 0, mhi = 0;
  int mbits = 0, mlevel = 0, mstrobe = 0;

  task automatic model_step();
    int s, w;
    if (!rst_n) begin
      mq1 = 1; mq2 = 1; mprev = 1; mlen = 0; mhi = 0;
      mbits = 0; mlevel = 0; mstrobe = 0;
      return;
    end
    if (!en) begin
      mprev = 1; mlen = 0; mhi = 0; mbits = 0; mlevel = 0; mstrobe = 0;
      mq2 = mq1; mq1 = int'(line);
      return;
    end
    s = mq2;
    mstrobe = 0;
    if (s == 1 && mprev == 0 && mhi != 0) begin
      w = mlen / TD;
      if (w >= 15 && w <= 45)       mbits = ((mbits << 1) | 1) & 31;
      else if (w >= 90 && w <= 120) mbits = (mbits << 1) & 31;
      else if (w >= 216) begin
        mlevel = mbits;
        mstrobe = 1;
      end
    end
    if (s != mprev) begin
      if (s == 0) mhi = (mlen / TD >= 3) ? 1 : 0;
      mlen = 1;
    end else if (mlen < 1000000) begin
      mlen++;
    end
    mprev = s;
    mq2 = mq1;
    mq1 = int'(line);
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk("R5 strobe per cycle", int'(strobe), mstrobe);
      chk("R2 level per cycle", int'(level), mlevel);
      if (strobe) nstrobe++;
      model_step();
    end
  end

  task automatic drive_cycles(input logic v, input int n);
    line = v;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic pulse(input int low_t, input int high_t);
    drive_cycles(1'b0, low_t * TD);
    drive_cycles(1'b1, high_t * TD);
  endtask

  task automatic send_bit(input int b);
    pulse(b != 0 ? 30 : 105, 10);
  endtask

  task automatic send_load();
    pulse(250, 10);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    en = 1'b1;
    drive_cycles(1'b1, 20 * TD);
    chk("R1 reset level", int'(level), 0);
    chk("R1 reset strobe", int'(strobe), 0);

    // R2: 1,0,1,0,0 then load -> 20
    base = nstrobe;
    send_bit(1); send_bit(0); send_bit(1); send_bit(0); send_bit(0);
    send_load();
    chk("R2 msb first level", int'(level), 20);
    chk("R5 one strobe per load", nstrobe - base, 1);

    // R3/R4 window edges: 15,90,45,120,15 -> 10101
    pulse(15, 10); pulse(90, 10); pulse(45, 10); pulse(120, 10); pulse(15, 10);
    send_load();
    chk("R3 R4 window edges", int'(level), 21);

    // R6: out-of-window pulses discarded
    base = nstrobe;
    for (int i = 0; i < 5; i++) send_bit(0);
    pulse(14, 10); pulse(46, 10); pulse(89, 10); pulse(121, 10); pulse(215, 10);
    chk("R6 gaps give no load", nstrobe - base, 0);
    send_load();
    chk("R6 discarded pulses", int'(level), 0);

    // R7: short high before a pulse voids it; exactly 3 ticks is accepted
    for (int i = 0; i < 4; i++) send_bit(1);
    pulse(30, 2);
    pulse(105, 10);
    send_load();
    chk("R7 short high voids pulse", int'(level), 31);
    pulse(30, 3);
    pulse(105, 10);
    send_load();
    chk("R7 three tick high accepted", int'(level), 30);

    // R11: seven bits, last five kept (1100110 -> 00110)
    send_bit(1); send_bit(1); send_bit(0); send_bit(0);
    send_bit(1); send_bit(1); send_bit(0);
    send_load();
    chk("R11 last five bits", int'(level), 6);

    // R10: very long low pulse still loads
    send_bit(1); send_bit(0); send_bit(0); send_bit(0); send_bit(1);
    pulse(700, 10);
    chk("R10 saturated width load", int'(level), 17);

    // R9/R12: edge-exact latency of a load
    send_bit(0); send_bit(1); send_bit(1); send_bit(0); send_bit(1);
    drive_cycles(1'b0, 216 * TD);
    line = 1'b1;
    @(posedge clk); #2;
    chk("R9 no strobe after edge 1", int'(strobe), 0);
    @(posedge clk); #2;
    chk("R9 no strobe after edge 2", int'(strobe), 0);
    chk("R9 level held after edge 2", int'(level), 17);
    @(posedge clk); #2;
    chk("R9 strobe after edge 3", int'(strobe), 1);
    chk("R12 216 ticks loads", int'(level), 13);
    @(posedge clk); #2;
    chk("R5 strobe single cycle", int'(strobe), 0);
    drive_cycles(1'b1, 10 * TD);

    // R8: disable clears, ignores the line, no restore
    for (int i = 0; i < 5; i++) send_bit(1);
    send_load();
    chk("R8 preload", int'(level), 31);
    en = 1'b0;
    @(posedge clk); #2;
    chk("R8 level cleared", int'(level), 0);
    send_bit(1);
    send_load();
    chk("R8 load ignored while disabled", int'(level), 0);
    en = 1'b1;
    drive_cycles(1'b1, 10 * TD);
    base = nstrobe;
    send_load();
    chk("R8 no restore after enable", int'(level), 0);
    chk("R8 load strobes after enable", nstrobe - base, 1);

    drive_cycles(1'b1, 10);
    finished = 1;
    summary();
    $finish;
  end
endmodule